// File: doc/BRIEF.md
# Enclave Tracking Request Checker

This block decides whether one request to start a tracking cycle on a page of a protected enclave page cache may go ahead. The surrounding logic resolves the page address and looks up the page's metadata and its control page. It then presents everything in one cycle with a valid strobe: the address, whether it lands in the page cache, whether the page is being modified, the metadata (valid bit, 3-bit page type, owning control-page index), whether another operation is using the control page's tracking facility, the control page's tracking-in-progress bit, its context value, and two virtualization qualifiers.

The checks are taken in a fixed priority order, and only the first failing check counts. A failure is reported in one of three ways: as a fault (general protection or page fault), as a result code with zero and carry flags, or as a virtualization exit record. The result code and flags are held in registers. A fault or an exit leaves them untouched, so the caller keeps the last architectural result.

All outputs are registered. A done pulse marks the cycle in which the outputs for a request become valid.

Top module: `trk_req_chk`

## Requirements
- R1: While rst_ni is low every output is 0, including done_o, fault_o, result_o, all flags and the whole exit record.
- R2: A request is taken when req_valid_i is high and done_o is low. done_o is then high for exactly the next cycle. A valid that arrives while done_o is high is ignored and changes no output.
- R3: If any of the low 12 address bits is set, fault_o is 1 (general protection). This overrides every other condition, and result_o, zf_o and cf_o keep their previous values.
- R4: If the address is aligned but does not resolve inside the page cache, fault_o is 2 (page fault) and fault_addr_o carries the address. fault_addr_o is 0 for every other outcome.
- R5: If the page is being modified (third priority), result_o is 7 with zf_o=1 and cf_o=0.
- R6: If the metadata valid bit is 0 (fourth priority), result_o is 6 with zf_o=1 and cf_o=0.
- R7: Page types are encoded as 0 control, 1 thread-control, 2 regular, 3 trim, 4 shadow-first, 5 shadow-rest. Types 6 and 7 give result_o 27 with zf_o=0 and cf_o=1. zf_o and cf_o are never both 1.
- R8: Once the type check passes, ctl_idx_o reports the control page. For type 0 this is address bits [19:12]; for the other tracked types it is meta_owner_i. When an earlier check fails, ctl_idx_o is 0.
- R9: If another operation is using the control page's tracking facility, result_o is 7 with zf_o=1 and cf_o=0. When nonroot_i and ext_en_i are both 1, the block instead raises an exit with qualification 0 (resource conflict).
- R10: If the control page's tracking bit is set, result_o is 17 with zf_o=1 and cf_o=0. When nonroot_i and ext_en_i are both 1, the block instead raises an exit with qualification 1 (reference conflict).
- R11: An exit sets exit_valid_o and exit_reason_o=71, copies ctl_ctx_i to exit_gpa_o, and drives 0 on exit_err_o and exit_gla_o. result_o, zf_o and cf_o keep their previous values.
- R12: When every check passes, result_o is 0 with zf_o=0 and cf_o=0. arith_flags_o is 0 after every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| page_addr_i | input | 64 | Target page address |
| in_cache_i | input | 1 | Address resolves inside the page cache |
| page_busy_i | input | 1 | Page is being modified |
| meta_valid_i | input | 1 | Metadata valid bit |
| meta_type_i | input | 3 | Page type code |
| meta_owner_i | input | 8 | Owning control-page index |
| other_trk_i | input | 1 | Tracking facility of the control page is in use |
| trk_busy_i | input | 1 | Control page tracking-in-progress bit |
| ctl_ctx_i | input | 64 | Control page context value |
| nonroot_i | input | 1 | Virtualization non-root mode |
| ext_en_i | input | 1 | Exit extension control |
| done_o | output | 1 | Outputs valid, one-cycle pulse |
| fault_o | output | 2 | 0 none, 1 general protection, 2 page fault |
| fault_addr_o | output | 64 | Faulting address |
| result_o | output | 64 | Result code |
| zf_o | output | 1 | Zero flag |
| cf_o | output | 1 | Carry flag |
| arith_flags_o | output | 4 | Cleared arithmetic flags {sf,of,af,pf} |
| ctl_idx_o | output | 8 | Resolved control page index |
| exit_valid_o | output | 1 | Exit record raised |
| exit_reason_o | output | 16 | Exit reason |
| exit_qual_o | output | 4 | Exit qualification code |
| exit_err_o | output | 32 | Exit error field |
| exit_gpa_o | output | 64 | Exit guest-physical address |
| exit_gla_o | output | 64 | Exit guest-linear address |

## Verification
Every result is due exactly one clock after the edge that accepts the request, because the decision logic feeds a single output register. The bench drives inputs on the falling edge and lets one rising edge capture them. It reads done_o and all outputs at the following falling edge, then checks one cycle later that done_o has dropped again. Since held results must survive faults and exits, the bench keeps its own copy of the last returned code and flags and compares against that copy.

// File: rtl/trk_pkg.sv
package trk_pkg;
  localparam int unsigned PAGE_SHIFT = 12;

  localparam logic [2:0] PT_CTL  = 3'd0;
  localparam logic [2:0] PT_TCS  = 3'd1;
  localparam logic [2:0] PT_REG  = 3'd2;
  localparam logic [2:0] PT_TRIM = 3'd3;
  localparam logic [2:0] PT_SHF  = 3'd4;
  localparam logic [2:0] PT_SHR  = 3'd5;

  localparam logic [7:0] RC_OK        = 8'd0;
  localparam logic [7:0] RC_INVALID   = 8'd6;
  localparam logic [7:0] RC_CONFLICT  = 8'd7;
  localparam logic [7:0] RC_PREV_BUSY = 8'd17;
  localparam logic [7:0] RC_NO_TRACK  = 8'd27;

  localparam logic [15:0] EXIT_RSN_CONFLICT = 16'd71;
  localparam logic [3:0]  QUAL_RESOURCE     = 4'd0;
  localparam logic [3:0]  QUAL_REFERENCE    = 4'd1;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_PF   = 2'd2
  } flt_e;

  typedef struct packed {
    flt_e       fault;
    logic       has_code;
    logic       keep_arith;
    logic [7:0] code;
    logic       zf;
    logic       cf;
    logic       exit_req;
    logic [3:0] qual;
    logic       ctl_known;
  } verdict_t;
endpackage

// File: rtl/trk_type_dec.sv
module trk_type_dec #(
  parameter int unsigned IDX_W = 8
) (
  input  logic [2:0]       ptype_i,
  input  logic [IDX_W-1:0] owner_i,
  input  logic [IDX_W-1:0] self_idx_i,
  output logic             tracked_o,
  output logic [IDX_W-1:0] ctl_idx_o
);
  import trk_pkg::*;

  always_comb begin
    tracked_o = 1'b1;
    ctl_idx_o = owner_i;
    unique case (ptype_i)
      PT_CTL:                                  ctl_idx_o = self_idx_i;
      PT_TCS, PT_REG, PT_TRIM, PT_SHF, PT_SHR: ctl_idx_o = owner_i;
      default: begin
        tracked_o = 1'b0;
        ctl_idx_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/trk_prio.sv
module trk_prio (
  input  logic [trk_pkg::PAGE_SHIFT-1:0] addr_lo_i,
  input  logic                           in_cache_i,
  input  logic                           page_busy_i,
  input  logic                           meta_valid_i,
  input  logic                           tracked_i,
  input  logic                           other_trk_i,
  input  logic                           trk_busy_i,
  input  logic                           vm_exit_en_i,
  output trk_pkg::verdict_t              verdict_o
);
  import trk_pkg::*;

  always_comb begin
    verdict_o       = '0;
    verdict_o.fault = FLT_NONE;
    if (|addr_lo_i) begin
      verdict_o.fault = FLT_GP;
    end else if (!in_cache_i) begin
      verdict_o.fault = FLT_PF;
    end else if (page_busy_i) begin
      // reported before the arithmetic flags are cleared
      verdict_o.has_code   = 1'b1;
      verdict_o.keep_arith = 1'b1;
      verdict_o.code       = RC_CONFLICT;
      verdict_o.zf         = 1'b1;
    end else if (!meta_valid_i) begin
      verdict_o.has_code = 1'b1;
      verdict_o.code     = RC_INVALID;
      verdict_o.zf       = 1'b1;
    end else if (!tracked_i) begin
      verdict_o.has_code = 1'b1;
      verdict_o.code     = RC_NO_TRACK;
      verdict_o.cf       = 1'b1;
    end else begin
      verdict_o.ctl_known = 1'b1;
      if (other_trk_i) begin
        if (vm_exit_en_i) begin
          verdict_o.exit_req = 1'b1;
          verdict_o.qual     = QUAL_RESOURCE;
        end else begin
          verdict_o.has_code = 1'b1;
          verdict_o.code     = RC_CONFLICT;
          verdict_o.zf       = 1'b1;
        end
      end else if (trk_busy_i) begin
        if (vm_exit_en_i) begin
          verdict_o.exit_req = 1'b1;
          verdict_o.qual     = QUAL_REFERENCE;
        end else begin
          verdict_o.has_code = 1'b1;
          verdict_o.code     = RC_PREV_BUSY;
          verdict_o.zf       = 1'b1;
        end
      end else begin
        verdict_o.has_code = 1'b1;
        verdict_o.code     = RC_OK;
      end
    end
  end
endmodule

// File: rtl/trk_resp_reg.sv
module trk_resp_reg #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned RES_W  = 64,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  trk_pkg::verdict_t verdict_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [IDX_W-1:0]  ctl_idx_i,
  input  logic [ADDR_W-1:0] ctx_i,
  output logic              done_o,
  output logic [1:0]        fault_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic [RES_W-1:0]  result_o,
  output logic              zf_o,
  output logic              cf_o,
  output logic [3:0]        arith_o,
  output logic [IDX_W-1:0]  ctl_idx_o,
  output logic              exit_valid_o,
  output logic [15:0]       exit_reason_o,
  output logic [3:0]        exit_qual_o,
  output logic [ADDR_W-1:0] exit_gpa_o
);
  import trk_pkg::*;

  localparam int unsigned CODE_PAD = RES_W - 8;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o        <= 1'b0;
      fault_o       <= '0;
      fault_addr_o  <= '0;
      result_o      <= '0;
      zf_o          <= 1'b0;
      cf_o          <= 1'b0;
      arith_o       <= '0;
      ctl_idx_o     <= '0;
      exit_valid_o  <= 1'b0;
      exit_reason_o <= '0;
      exit_qual_o   <= '0;
      exit_gpa_o    <= '0;
    end else begin
      done_o <= fire_i;
      if (fire_i) begin
        fault_o       <= verdict_i.fault;
        fault_addr_o  <= (verdict_i.fault == FLT_PF) ? addr_i : '0;
        ctl_idx_o     <= verdict_i.ctl_known ? ctl_idx_i : '0;
        exit_valid_o  <= verdict_i.exit_req;
        exit_reason_o <= verdict_i.exit_req ? EXIT_RSN_CONFLICT : '0;
        exit_qual_o   <= verdict_i.exit_req ? verdict_i.qual : '0;
        exit_gpa_o    <= verdict_i.exit_req ? ctx_i : '0;
        if (verdict_i.has_code) begin
          result_o <= {{CODE_PAD{1'b0}}, verdict_i.code};
          zf_o     <= verdict_i.zf;
          cf_o     <= verdict_i.cf;
          if (!verdict_i.keep_arith) arith_o <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/trk_req_chk.sv
module trk_req_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned RES_W  = 64,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] page_addr_i,
  input  logic              in_cache_i,
  input  logic              page_busy_i,
  input  logic              meta_valid_i,
  input  logic [2:0]        meta_type_i,
  input  logic [IDX_W-1:0]  meta_owner_i,
  input  logic              other_trk_i,
  input  logic              trk_busy_i,
  input  logic [ADDR_W-1:0] ctl_ctx_i,
  input  logic              nonroot_i,
  input  logic              ext_en_i,
  output logic              done_o,
  output logic [1:0]        fault_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic [RES_W-1:0]  result_o,
  output logic              zf_o,
  output logic              cf_o,
  output logic [3:0]        arith_flags_o,
  output logic [IDX_W-1:0]  ctl_idx_o,
  output logic              exit_valid_o,
  output logic [15:0]       exit_reason_o,
  output logic [3:0]        exit_qual_o,
  output logic [31:0]       exit_err_o,
  output logic [ADDR_W-1:0] exit_gpa_o,
  output logic [ADDR_W-1:0] exit_gla_o
);
  import trk_pkg::*;

  localparam int unsigned PS = PAGE_SHIFT;

  logic             fire;
  logic             tracked;
  logic [IDX_W-1:0] ctl_idx;
  verdict_t         verdict;

  // idle means no response is being presented
  assign fire = req_valid_i & ~done_o;

  trk_type_dec #(.IDX_W(IDX_W)) i_type_dec (
    .ptype_i    (meta_type_i),
    .owner_i    (meta_owner_i),
    .self_idx_i (page_addr_i[PS +: IDX_W]),
    .tracked_o  (tracked),
    .ctl_idx_o  (ctl_idx)
  );

  trk_prio i_prio (
    .addr_lo_i    (page_addr_i[PS-1:0]),
    .in_cache_i   (in_cache_i),
    .page_busy_i  (page_busy_i),
    .meta_valid_i (meta_valid_i),
    .tracked_i    (tracked),
    .other_trk_i  (other_trk_i),
    .trk_busy_i   (trk_busy_i),
    .vm_exit_en_i (nonroot_i & ext_en_i),
    .verdict_o    (verdict)
  );

  trk_resp_reg #(.ADDR_W(ADDR_W), .RES_W(RES_W), .IDX_W(IDX_W)) i_resp (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fire_i        (fire),
    .verdict_i     (verdict),
    .addr_i        (page_addr_i),
    .ctl_idx_i     (ctl_idx),
    .ctx_i         (ctl_ctx_i),
    .done_o        (done_o),
    .fault_o       (fault_o),
    .fault_addr_o  (fault_addr_o),
    .result_o      (result_o),
    .zf_o          (zf_o),
    .cf_o          (cf_o),
    .arith_o       (arith_flags_o),
    .ctl_idx_o     (ctl_idx_o),
    .exit_valid_o  (exit_valid_o),
    .exit_reason_o (exit_reason_o),
    .exit_qual_o   (exit_qual_o),
    .exit_gpa_o    (exit_gpa_o)
  );

  assign exit_err_o = '0;
  assign exit_gla_o = '0;
endmodule

// File: rtl/trk_req_chk_chk.sv
module trk_req_chk_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned RES_W  = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              done_o,
  input logic [1:0]        fault_o,
  input logic [ADDR_W-1:0] fault_addr_o,
  input logic [RES_W-1:0]  result_o,
  input logic              zf_o,
  input logic              cf_o,
  input logic [3:0]        arith_flags_o,
  input logic              exit_valid_o,
  input logic [15:0]       exit_reason_o
);
  // R2
  accept_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !done_o) |=> done_o);
  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  no_req_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i || done_o) |=> !done_o);
  // R3
  fault_no_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o != 2'd0) |-> !exit_valid_o);
  // R4
  pf_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o == 2'd2) |-> (fault_addr_o[11:0] == 12'd0));
  // R11
  keep_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (fault_o != 2'd0 || exit_valid_o)) |->
      ($stable(result_o) && $stable(zf_o) && $stable(cf_o)));
  // R11
  exit_reason_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_valid_o |-> (exit_reason_o == 16'd71));
  // R7
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(zf_o && cf_o));
  // R12
  arith_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (arith_flags_o == 4'd0));
endmodule

bind trk_req_chk trk_req_chk_chk #(.ADDR_W(ADDR_W), .RES_W(RES_W)) i_trk_req_chk_chk (.*);

// File: tb/test_trk_req_chk.sv
`timescale 1ns/1ps
module test_trk_req_chk;
  localparam int unsigned AW = 64;
  localparam int unsigned RW = 64;
  localparam int unsigned IW = 8;
  localparam logic [AW-1:0] BASE  = 64'h0000_0012_3456_7000;
  localparam logic [AW-1:0] CTX   = 64'hC0DE_0000_0000_1234;
  localparam logic [IW-1:0] OWNER = 8'hA5;
  localparam logic [IW-1:0] SELF  = 8'h67;

  typedef struct packed {
    logic       misal, nores, busy, inval;
    logic [2:0] ptype;
    logic       oth, trk, vm;
    logic [1:0] e_fault;
    logic [7:0] e_code;
    logic       e_zf, e_cf, e_exit;
    logic [3:0] e_qual;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,3'd2,1'b0,1'b0,1'b0, 2'd0,8'd0, 1'b0,1'b0,1'b0,4'd0},
    '{1'b1,1'b1,1'b1,1'b0,3'd2,1'b0,1'b0,1'b0, 2'd1,8'd0, 1'b0,1'b0,1'b0,4'd0},
    '{1'b0,1'b1,1'b1,1'b1,3'd2,1'b0,1'b0,1'b0, 2'd2,8'd0, 1'b0,1'b0,1'b0,4'd0},
    '{1'b0,1'b0,1'b1,1'b1,3'd7,1'b0,1'b0,1'b0, 2'd0,8'd7, 1'b1,1'b0,1'b0,4'd0},
    '{1'b0,1'b0,1'b0,1'b1,3'd6,1'b0,1'b0,1'b0, 2'd0,8'd6, 1'b1,1'b0,1'b0,4'd0},
    '{1'b0,1'b0,1'b0,1'b0,3'd6,1'b1,1'b1,1'b1, 2'd0,8'd27,1'b0,1'b1,1'b0,4'd0},
    '{1'b0,1'b0,1'b0,1'b0,3'd7,1'b0,1'b0,1'b0, 2'd0,8'd27,1'b0,1'b1,1'b0,4'd0},
    '{1'b0,1'b0,1'b0,1'b0,3'd1,1'b1,1'b1,1'b0, 2'd0,8'd7, 1'b1,1'b0,1'b0,4'd0},
    '{1'b0,1'b0,1'b0,1'b0,3'd3,1'b1,1'b1,1'b1, 2'd0,8'd0, 1'b0,1'b0,1'b1,4'd0},
    '{1'b0,1'b0,1'b0,1'b0,3'd4,1'b0,1'b1,1'b0, 2'd0,8'd17,1'b1,1'b0,1'b0,4'd0},
    '{1'b0,1'b0,1'b0,1'b0,3'd5,1'b0,1'b1,1'b1, 2'd0,8'd0, 1'b0,1'b0,1'b1,4'd1},
    '{1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 2'd0,8'd0, 1'b0,1'b0,1'b0,4'd0},
    '{1'b1,1'b0,1'b0,1'b0,3'd7,1'b0,1'b0,1'b0, 2'd1,8'd0, 1'b0,1'b0,1'b0,4'd0},
    '{1'b0,1'b0,1'b1,1'b0,3'd0,1'b1,1'b0,1'b1, 2'd0,8'd7, 1'b1,1'b0,1'b0,4'd0},
    '{1'b0,1'b0,1'b0,1'b0,3'd3,1'b0,1'b0,1'b0, 2'd0,8'd0, 1'b0,1'b0,1'b0,4'd0},
    '{1'b0,1'b0,1'b0,1'b0,3'd5,1'b0,1'b0,1'b0, 2'd0,8'd0, 1'b0,1'b0,1'b0,4'd0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [AW-1:0] page_addr_i = '0;
  logic in_cache_i = 1'b0, page_busy_i = 1'b0, meta_valid_i = 1'b0;
  logic [2:0] meta_type_i = '0;
  logic [IW-1:0] meta_owner_i = '0;
  logic other_trk_i = 1'b0, trk_busy_i = 1'b0;
  logic [AW-1:0] ctl_ctx_i = '0;
  logic nonroot_i = 1'b0, ext_en_i = 1'b0;
  logic done_o;
  logic [1:0] fault_o;
  logic [AW-1:0] fault_addr_o;
  logic [RW-1:0] result_o;
  logic zf_o, cf_o;
  logic [3:0] arith_flags_o;
  logic [IW-1:0] ctl_idx_o;
  logic exit_valid_o;
  logic [15:0] exit_reason_o;
  logic [3:0] exit_qual_o;
  logic [31:0] exit_err_o;
  logic [AW-1:0] exit_gpa_o, exit_gla_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [RW-1:0] m_res = '0;
  logic m_zf = 1'b0, m_cf = 1'b0;

  always #4 clk_i = ~clk_i;

  trk_req_chk #(.ADDR_W(AW), .RES_W(RW), .IDX_W(IW)) i_trk_req_chk (.*);

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.e_fault == 2'd1) return "R3";
    if (v.e_fault == 2'd2) return "R4";
    if (v.e_exit) return (v.e_qual == 4'd0) ? "R9" : "R10";
    if (v.busy) return "R5";
    case (v.e_code)
      8'd6:    return "R6";
      8'd27:   return "R7";
      8'd7:    return "R9";
      8'd17:   return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic drive(input vec_t v);
    page_addr_i  = BASE | (v.misal ? 64'h8 : 64'h0);
    in_cache_i   = ~v.nores;
    page_busy_i  = v.busy;
    meta_valid_i = ~v.inval;
    meta_type_i  = v.ptype;
    meta_owner_i = OWNER;
    other_trk_i  = v.oth;
    trk_busy_i   = v.trk;
    ctl_ctx_i    = CTX;
    nonroot_i    = v.vm;
    ext_en_i     = v.vm;
  endtask

  task automatic run_vec(input int idx, input vec_t v);
    string t;
    logic early;
    logic [IW-1:0] e_idx;
    t = tag_of(v);
    @(negedge clk_i);
    drive(v);
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (v.e_fault == 2'd0 && !v.e_exit) begin
      m_res = {56'd0, v.e_code};
      m_zf  = v.e_zf;
      m_cf  = v.e_cf;
    end
    early = v.misal | v.nores | v.busy | v.inval | (v.ptype > 3'd5);
    e_idx = early ? '0 : ((v.ptype == 3'd0) ? SELF : OWNER);
    $display("vector %0d (%s)", idx, t);
    chk("R2", "done", done_o, 1);
    chk(t, "fault", fault_o, v.e_fault);
    chk("R4", "fault_addr", fault_addr_o, (v.e_fault == 2'd2) ? page_addr_i : 64'd0);
    chk(t, "result", result_o, m_res);
    chk(t, "zf", zf_o, m_zf);
    chk(t, "cf", cf_o, m_cf);
    chk("R12", "arith", arith_flags_o, 0);
    chk("R8", "ctl_idx", ctl_idx_o, e_idx);
    chk(t, "exit_valid", exit_valid_o, v.e_exit);
    chk(t, "exit_qual", exit_qual_o, v.e_exit ? v.e_qual : 4'd0);
    chk("R11", "exit_gpa", exit_gpa_o, v.e_exit ? CTX : 64'd0);
    chk("R11", "exit_reason", exit_reason_o, v.e_exit ? 64'd71 : 64'd0);
    chk("R11", "exit_err", exit_err_o, 0);
    chk("R11", "exit_gla", exit_gla_o, 0);
    @(negedge clk_i);
    chk("R2", "done_drop", done_o, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    vec_t w;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "done", done_o, 0);
    chk("R1", "fault", fault_o, 0);
    chk("R1", "result", result_o, 0);
    chk("R1", "flags", {zf_o, cf_o, arith_flags_o}, 0);
    chk("R1", "exit", {exit_valid_o, exit_reason_o, exit_qual_o}, 0);
    chk("R1", "gpa", exit_gpa_o, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);

    // R9 non-root without extension control returns a code, no exit
    w = VECS[8];
    w.vm = 1'b0; w.e_exit = 1'b0; w.e_code = 8'd7; w.e_zf = 1'b1;
    run_vec(100, w);
    @(negedge clk_i);
    drive(VECS[8]); nonroot_i = 1'b1; ext_en_i = 1'b0;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R9", "nonroot_only_exit", exit_valid_o, 0);
    chk("R9", "nonroot_only_code", result_o, 7);

    // R2 held valid: second cycle ignored, first result kept
    @(negedge clk_i);
    drive(VECS[6]);
    req_valid_i = 1'b1;
    @(negedge clk_i);
    chk("R2", "held_done1", done_o, 1);
    chk("R2", "held_result", result_o, 27);
    drive(VECS[4]);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R2", "held_done2", done_o, 0);
    chk("R2", "ignored_result", result_o, 27);
    chk("R2", "ignored_cf", cf_o, 1);
    m_res = 64'd27; m_zf = 1'b0; m_cf = 1'b1;

    // R11 exit after a known result keeps that result
    run_vec(101, VECS[10]);

    // R1 asynchronous reset mid-stream
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1", "mid_result", result_o, 0);
    chk("R1", "mid_cf", cf_o, 0);
    chk("R1", "mid_done", done_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule